// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation tree that sits in ordinary memory. A request is taken only while the walker is idle. At that moment the walker latches the virtual address and the base of the first-level directory. It then fetches one or two 32-bit entries through a read port that allows a single read in flight. The walk ends with either a one-cycle completion pulse that carries the physical address, or a one-cycle fault pulse that carries a reason code and the virtual address that failed.

The virtual address has three fields. The directory index is bits 31:22, the table index is bits 21:12 and the byte offset is bits 11:0. Each entry is four bytes wide. Its upper 20 bits give the 4 KiB-aligned base of the next level. Bit 0 is the valid flag. In a directory entry only, bit 7 marks a 4 MiB mapping. A first-level entry with that flag set ends the walk after a single read.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and just after it, `reqReady` is 1 and `memReqValid`, `doneValid` and `faultValid` are all 0.
- R2: A request is taken only in a cycle where `reqReady` is 1. `reqReady` stays 0 from acceptance until the cycle after the end pulse. `reqValid` and `reqVaddr` seen while busy have no effect on the walk in progress, and they start no further reads.
- R3: The first read address is `{rootBase[31:12], va[31:22], 2'b00}`. `rootBase` is sampled only on the accepting edge, so later changes to it do not alter the walk.
- R4: `memReqValid` with its `memReqAddr` is held steady until `memReqReady` is seen high. A new read is never issued while a response is still awaited.
- R5: For a small page, the second read address is `{pde[31:12], va[21:12], 2'b00}`. The result is `physAddr = {pte[31:12], va[11:0]}` with one `doneValid` pulse, after exactly two reads.
- R6: A directory entry with bit 0 = 1 and bit 7 = 1 ends the walk after one read, with `physAddr = {pde[31:22], va[21:0]}`.
- R7: A directory entry with bit 0 = 0 raises `faultValid` with `faultCode = 2'b01` and `faultVaddr = va`, after one read, whatever bit 7 holds.
- R8: A second-level entry with bit 0 = 0 raises `faultValid` with `faultCode = 2'b10` and `faultVaddr = va`, after two reads.
- R9: `doneValid` and `faultValid` are never high together. Each is a single-cycle pulse, and `reqReady` returns to 1 in the cycle after it.
- R10: A response beat that arrives while no read is outstanding is ignored. It raises no pulse and leaves `reqReady` at 1.
- R11: Bit 7 of a second-level entry has no effect. Such an entry still translates as a 4 KiB page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Walker is idle and will take a request |
| reqVaddr | input | 32 | Virtual address to translate |
| rootBase | input | 32 | Physical base of the directory (bits 31:12 used) |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory accepts the read request |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data beat |
| memRspData | input | 32 | Entry read from memory |
| doneValid | output | 1 | One-cycle successful translation pulse |
| physAddr | output | 32 | Translated physical address |
| faultValid | output | 1 | One-cycle fault pulse |
| faultCode | output | 2 | 01 directory entry not valid, 10 table entry not valid |
| faultVaddr | output | 32 | Virtual address that faulted |

## Verification
Two events can land on the same edge. One is the end pulse of a walk. The other is a caller that keeps `reqValid` high with a new address and a changed root while the walk is still busy. The bench holds the request line high across the start of each walk, swaps the address and the root right after acceptance, and lets the memory model stall `memReqReady` and delay responses. Each walk is then judged on four things: its own result, the addresses it read, the number of reads it made, and whether `reqReady` stayed low until the pulse had passed.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int VA_W        = 32;
  localparam int OFF_W       = 12;
  localparam int IDX_W       = 10;
  localparam int ENTRY_LOG2  = 2;
  localparam int PRESENT_BIT = 0;
  localparam int LARGE_BIT   = 7;
  localparam int FRAME_W     = VA_W - OFF_W;
  localparam int LARGE_OFF_W = OFF_W + IDX_W;
  localparam int LARGE_FR_W  = VA_W - LARGE_OFF_W;
  localparam int CODE_W      = 2;

  localparam logic [CODE_W-1:0] CODE_DIR_MISS = 2'b01;
  localparam logic [CODE_W-1:0] CODE_TBL_MISS = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PDE_REQ, ST_PDE_WAIT, ST_PTE_REQ, ST_PTE_WAIT, ST_DONE, ST_FAULT
  } walkState_e;

  typedef struct packed {
    logic capReq;
    logic capPde;
    logic selPte;
    logic capSmall;
    logic capLarge;
    logic capFault;
    logic faultLvl2;
  } walkStrobe_t;
endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        memReqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        rspPresent,
  input  logic        rspLarge,
  output logic        doneValid,
  output logic        faultValid,
  output walkStrobe_t strobe
);
  walkState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    strobe      = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    doneValid   = 1'b0;
    faultValid  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capReq = 1'b1;
          stateD = ST_PDE_REQ;
        end
      end
      ST_PDE_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateD = ST_PDE_WAIT;
      end
      ST_PDE_WAIT: begin
        if (memRspValid) begin
          if (!rspPresent) begin
            strobe.capFault = 1'b1;
            stateD = ST_FAULT;
          end else if (rspLarge) begin
            strobe.capLarge = 1'b1;
            stateD = ST_DONE;
          end else begin
            strobe.capPde = 1'b1;
            stateD = ST_PTE_REQ;
          end
        end
      end
      ST_PTE_REQ: begin
        strobe.selPte = 1'b1;
        memReqValid = 1'b1;
        if (memReqReady) stateD = ST_PTE_WAIT;
      end
      ST_PTE_WAIT: begin
        strobe.selPte = 1'b1;
        if (memRspValid) begin
          if (!rspPresent) begin
            strobe.capFault  = 1'b1;
            strobe.faultLvl2 = 1'b1;
            stateD = ST_FAULT;
          end else begin
            strobe.capSmall = 1'b1;
            stateD = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        doneValid = 1'b1;
        stateD = ST_IDLE;
      end
      ST_FAULT: begin
        faultValid = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(doneValid && faultValid)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid && reqReady); // R9
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    faultValid |=> !faultValid && reqReady); // R9
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> !memReqValid); // R2
  AST_STRAY_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (reqReady && !reqValid) |=> reqReady); // R10
endmodule

// File: rtl/walk_dp.sv
module walk_dp
  import walk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  walkStrobe_t       strobe,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [VA_W-1:0]   rootBase,
  input  logic [VA_W-1:0]   memRspData,
  output logic [VA_W-1:0]   memReqAddr,
  output logic              rspPresent,
  output logic              rspLarge,
  output logic [VA_W-1:0]   physAddr,
  output logic [CODE_W-1:0] faultCode,
  output logic [VA_W-1:0]   faultVaddr
);
  logic [VA_W-1:0]    vaddrQ;
  logic [FRAME_W-1:0] rootQ;
  logic [FRAME_W-1:0] tableQ;
  logic [VA_W-1:0]    physQ;
  logic [CODE_W-1:0]  codeQ;

  logic [IDX_W-1:0] dirIdx;
  logic [IDX_W-1:0] tblIdx;
  assign dirIdx = vaddrQ[VA_W-1 -: IDX_W];
  assign tblIdx = vaddrQ[LARGE_OFF_W-1 -: IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaddrQ <= '0;
      rootQ  <= '0;
      tableQ <= '0;
      physQ  <= '0;
      codeQ  <= '0;
    end else begin
      if (strobe.capReq) begin
        vaddrQ <= reqVaddr;
        rootQ  <= rootBase[VA_W-1 -: FRAME_W];
      end
      if (strobe.capPde)
        tableQ <= memRspData[VA_W-1 -: FRAME_W];
      if (strobe.capLarge)
        physQ <= {memRspData[VA_W-1 -: LARGE_FR_W], vaddrQ[LARGE_OFF_W-1:0]};
      if (strobe.capSmall)
        physQ <= {memRspData[VA_W-1 -: FRAME_W], vaddrQ[OFF_W-1:0]};
      if (strobe.capFault)
        codeQ <= strobe.faultLvl2 ? CODE_TBL_MISS : CODE_DIR_MISS;
    end
  end

  assign memReqAddr = strobe.selPte ? {tableQ, tblIdx, {ENTRY_LOG2{1'b0}}}
                                    : {rootQ, dirIdx, {ENTRY_LOG2{1'b0}}};
  assign rspPresent = memRspData[PRESENT_BIT];
  assign rspLarge   = memRspData[LARGE_BIT];
  assign physAddr   = physQ;
  assign faultCode  = codeQ;
  assign faultVaddr = vaddrQ;

  AST_VA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capReq |=> $stable(vaddrQ)); // R2
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capFault |=> (codeQ == CODE_DIR_MISS || codeQ == CODE_TBL_MISS)); // R7
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import walk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [VA_W-1:0]   rootBase,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [VA_W-1:0]   memReqAddr,
  input  logic              memRspValid,
  input  logic [VA_W-1:0]   memRspData,
  output logic              doneValid,
  output logic [VA_W-1:0]   physAddr,
  output logic              faultValid,
  output logic [CODE_W-1:0] faultCode,
  output logic [VA_W-1:0]   faultVaddr
);
  walkStrobe_t strobe;
  logic rspPresent;
  logic rspLarge;

  walk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqReady(reqReady),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .rspPresent(rspPresent), .rspLarge(rspLarge),
    .doneValid(doneValid), .faultValid(faultValid),
    .strobe(strobe)
  );

  walk_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .reqVaddr(reqVaddr), .rootBase(rootBase),
    .memRspData(memRspData), .memReqAddr(memReqAddr),
    .rspPresent(rspPresent), .rspLarge(rspLarge),
    .physAddr(physAddr), .faultCode(faultCode), .faultVaddr(faultVaddr)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr))); // R4
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && memReqReady) |=> !memReqValid); // R4
endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [31:0] reqVaddr = '0;
  logic [31:0] rootBase = '0;
  logic memReqValid;
  logic memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic doneValid;
  logic [31:0] physAddr;
  logic faultValid;
  logic [1:0] faultCode;
  logic [31:0] faultVaddr;

  always #4 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .rootBase(rootBase),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .doneValid(doneValid), .physAddr(physAddr),
    .faultValid(faultValid), .faultCode(faultCode), .faultVaddr(faultVaddr)
  );

  int compared = 0;
  int mismatched = 0;
  logic [31:0] mem [logic [31:0]];
  int readCount = 0;
  int overlapCount = 0;
  logic [31:0] readAddr [0:1];
  int rspLatency = 0;
  logic stallMode = 1'b0;
  logic injectStray = 1'b0;

  function automatic logic [31:0] memRead(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: one read in flight, optional ready stalls and latency
  initial begin
    logic pend;
    int cnt;
    logic [31:0] addr;
    pend = 1'b0; cnt = 0; addr = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (injectStray) begin
        memRspValid = 1'b1;
        memRspData = 32'h0000_0081;
      end
      if (pend) begin
        if (cnt == 0) begin
          memRspValid = 1'b1;
          memRspData = memRead(addr);
          pend = 1'b0;
        end else cnt--;
      end
      memReqReady = stallMode ? ~memReqReady : 1'b1;
      if (memReqValid && memReqReady) begin
        if (pend || memRspValid) overlapCount++;
        if (readCount < 2) readAddr[readCount] = memReqAddr;
        readCount++;
        pend = 1'b1;
        addr = memReqAddr;
        cnt = rspLatency;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] root, input int hold,
                      input string req, output logic gotDone, output logic gotFault);
    readCount = 0;
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; rootBase = root;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    rootBase = 32'hDEAD_0000;
    reqVaddr = 32'h8000_0000;
    for (int i = 0; i < hold; i++) begin
      check({req, " busy reqReady"}, {31'h0, reqReady}, 32'h0);
      @(negedge clk);
    end
    reqValid = 1'b0;
    for (int i = 0; i < 200 && !(doneValid || faultValid); i++) @(negedge clk);
    gotDone = doneValid;
    gotFault = faultValid;
    check({req, " R9 exclusive"}, {31'h0, doneValid & faultValid}, 32'h0);
  endtask

  task automatic afterPulse(input string req);
    @(negedge clk);
    check({req, " R9 pulse gone"}, {30'h0, doneValid, faultValid}, 32'h0);
    check({req, " R9 ready back"}, {31'h0, reqReady}, 32'h1);
  endtask

  task automatic testReset();
    check("R1 reqReady", {31'h0, reqReady}, 32'h1);
    check("R1 memReqValid", {31'h0, memReqValid}, 32'h0);
    check("R1 strobes", {30'h0, doneValid, faultValid}, 32'h0);
  endtask

  task automatic testSmall(input int lat, input logic stall, input int hold);
    logic d, f;
    rspLatency = lat; stallMode = stall;
    walk(32'h0040_3ABC, 32'h0001_0000, hold, "R5", d, f);
    check("R5 done", {31'h0, d}, 32'h1);
    check("R5 phys", physAddr, 32'h0ABC_DABC);
    check("R5 reads", readCount, 2);
    check("R3 dir addr", readAddr[0], 32'h0001_0004);
    check("R5 tbl addr", readAddr[1], 32'h0002_000C);
    afterPulse("R5");
    check("R2 no extra read", readCount, 2);
    stallMode = 1'b0; rspLatency = 0;
  endtask

  task automatic testLarge();
    logic d, f;
    walk(32'h0C12_3456, 32'h0001_0000, 1, "R6", d, f);
    check("R6 done", {31'h0, d}, 32'h1);
    check("R6 phys", physAddr, 32'h1852_3456);
    check("R6 reads", readCount, 1);
    check("R6 dir addr", readAddr[0], 32'h0001_00C0);
    afterPulse("R6");
  endtask

  task automatic testDirFault(input logic [31:0] va, input logic [31:0] expAddr);
    logic d, f;
    walk(va, 32'h0001_0000, 0, "R7", d, f);
    check("R7 fault", {31'h0, f}, 32'h1);
    check("R7 code", {30'h0, faultCode}, 32'h1);
    check("R7 vaddr", faultVaddr, va);
    check("R7 reads", readCount, 1);
    check("R7 dir addr", readAddr[0], expAddr);
    afterPulse("R7");
  endtask

  task automatic testTblFault();
    logic d, f;
    rspLatency = 2;
    walk(32'h0040_5000, 32'h0001_0000, 2, "R8", d, f);
    check("R8 fault", {31'h0, f}, 32'h1);
    check("R8 code", {30'h0, faultCode}, 32'h2);
    check("R8 vaddr", faultVaddr, 32'h0040_5000);
    check("R8 reads", readCount, 2);
    check("R8 tbl addr", readAddr[1], 32'h0002_0014);
    afterPulse("R8");
    rspLatency = 0;
  endtask

  task automatic testTblLargeFlag();
    logic d, f;
    walk(32'h0040_7123, 32'h0001_0000, 0, "R11", d, f);
    check("R11 done", {31'h0, d}, 32'h1);
    check("R11 phys", physAddr, 32'h0123_4123);
    check("R11 reads", readCount, 2);
    afterPulse("R11");
  endtask

  task automatic testRootSample();
    logic d, f;
    walk(32'h0000_0456, 32'h0005_0000, 2, "R3", d, f);
    check("R3 done", {31'h0, d}, 32'h1);
    check("R3 root sampled", readAddr[0], 32'h0005_0000);
    check("R3 phys", physAddr, 32'h0077_7456);
    afterPulse("R3");
  endtask

  task automatic testStray();
    readCount = 0;
    @(negedge clk);
    injectStray = 1'b1;
    @(negedge clk);
    injectStray = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check("R10 no pulse", {30'h0, doneValid, faultValid}, 32'h0);
      check("R10 still ready", {31'h0, reqReady}, 32'h1);
      @(negedge clk);
    end
    check("R10 no read", readCount, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    mem[32'h0001_0004] = 32'h0002_0001;
    mem[32'h0002_000C] = 32'h0ABC_D003;
    mem[32'h0001_00C0] = 32'h1840_0081;
    mem[32'h0001_0804] = 32'h0000_0080;
    mem[32'h0002_0014] = 32'h0F00_0002;
    mem[32'h0002_001C] = 32'h0123_4081;
    mem[32'h0005_0000] = 32'h0006_0001;
    mem[32'h0006_0000] = 32'h0077_7001;
    repeat (3) @(negedge clk);
    testReset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testSmall(0, 1'b0, 0);
    testSmall(3, 1'b1, 2);
    testLarge();
    testDirFault(32'h8000_0000, 32'h0001_0800);
    testDirFault(32'h8040_0000, 32'h0001_0804);
    testTblFault();
    testTblLargeFlag();
    testRootSample();
    testStray();
    check("R4 single outstanding", overlapCount, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule